// File: doc/BRIEF.md
# Two-Zone Temperature Event Filter and Interrupt Controller

This block watches temperature readings for two zones as they come out of a converter, one conversion at a time. Each zone has a set limit and a lower hysteresis limit. A zone becomes "hot" only after a run of consecutive conversions above its set limit. It becomes "cool" again only after a run of the same length below its hysteresis limit. The run length comes from a two-bit depth code, so a single noisy reading cannot trip the zone or release it.

Qualified events update sticky per-zone status bits and drive an active-low interrupt line. The line has two behaviours. In comparator mode it follows the hot state of the zones. In interrupt mode it latches on each qualified crossing, either upward or back downward. A read of any register releases the line, and only a read of the status register clears the status bits. A shutdown control stops all event processing. It also releases the line and clears the status and the interrupt latch.

Top module: `tzone_irq_ctrl`

## Requirements
- R1: The depth code selects the number of consecutive qualifying conversions for a zone: code 0 needs 1, code 1 needs 2, code 2 needs 4 and code 3 needs 6. A zone turns hot on the clock edge that samples the last conversion of the run.
- R2: A conversion for a zone that does not meet the condition being counted resets that zone's run, so the full run count is needed again afterwards.
- R3: Each zone counts only its own conversions (zone index 0 or 1). A conversion tagged for one zone neither advances nor resets the other zone's run.
- R4: A hot zone turns cool only after a full run of conversions strictly below its hysteresis limit. A reading equal to the hysteresis limit does not count toward that run.
- R5: A qualified event sets the zone status bit (zone_stat[z]) whatever the mask is. The bit stays set through further events and through reads of other registers. Only a status read clears it, and an event in the same cycle as that read wins.
- R6: In interrupt mode (mode_intr=1) with irq_mask=0, a qualified event drives irq_n low until a read of any register. With irq_mask=1, irq_n stays high, even after the mask is lifted later.
- R7: In interrupt mode, after an upward event, further readings above the set limit raise no new interrupt. The next interrupt comes from the downward event through the hysteresis limit, and the one after that from a new upward event.
- R8: In comparator mode (mode_intr=0), irq_n is low exactly when at least one zone is hot and irq_mask=0. Register reads do not release it.
- R9: While shutdown is 1, irq_n is high and both status bits read 0, and conversions change no zone state. The interrupt latch is cleared, so leaving shutdown does not bring back an old interrupt.
- R10: Temperatures and limits are 8-bit two's-complement values, and every comparison is signed.
- R11: After reset, irq_n is 1, and all status bits and hot flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | One-cycle strobe: a new conversion result is present |
| conv_zone | input | 1 | Zone index of the conversion result |
| conv_temp | input | 8 | Conversion result, two's complement |
| set_lim | input | 16 | Set limits, zone z at bits [8z+7:8z], two's complement |
| hyst_lim | input | 16 | Hysteresis limits, zone z at bits [8z+7:8z], two's complement |
| qdepth | input | 2 | Run-length code: 0→1, 1→2, 2→4, 3→6 conversions |
| mode_intr | input | 1 | 0 = comparator mode, 1 = interrupt mode |
| irq_mask | input | 1 | 1 blocks the interrupt output |
| shutdown | input | 1 | 1 stops event processing and quiets the outputs |
| stat_rd | input | 1 | Strobe: the status register is being read |
| any_rd | input | 1 | Strobe: some other register is being read |
| irq_n | output | 1 | Active-low interrupt, registered |
| zone_stat | output | 2 | Sticky per-zone status bits, registered |
| zone_hot | output | 2 | Filtered hot state per zone |

## Verification
The bench goes after the off-by-one edges of the run counter. For every depth code and both zones it stops one conversion short of the run and breaks the run with a reading exactly at the limit. A counter that mis-decodes the nonlinear code, does not reset on a miss, or treats equal as over would trip early or late. Full sweeps over all 256 temperatures, checked against both the set and the hysteresis limit of a zone with negative limits, catch an unsigned compare or a wrong inequality. Interrupt-mode sequences then check three points. A second upward reading must not fire again. An ordinary register read must release the line but keep the status. A status read that coincides with a new event must keep the bit. Shutdown checks confirm that a stale latch does not return when shutdown ends.

// File: rtl/tz_pkg.sv
package tz_pkg;
  localparam int QCNT_W = 3;

  // Nonlinear run-length decode: 1, 2, 4, 6 conversions.
  function automatic logic [QCNT_W-1:0] run_len(input logic [1:0] code);
    logic [QCNT_W-1:0] n;
    case (code)
      2'd0:    n = QCNT_W'(1);
      2'd1:    n = QCNT_W'(2);
      2'd2:    n = QCNT_W'(4);
      default: n = QCNT_W'(6);
    endcase
    return n;
  endfunction
endpackage

// File: rtl/tz_fault_queue.sv
module tz_fault_queue #(
  parameter int TW = 8,
  parameter int CW = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hit,
  input  logic                 run,
  input  logic signed [TW-1:0] temp,
  input  logic signed [TW-1:0] set_lim,
  input  logic signed [TW-1:0] hyst_lim,
  input  logic [CW-1:0]        need,
  output logic                 hot_q,
  output logic                 hot_d,
  output logic                 evt_over,
  output logic                 evt_under
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   cnt_inc;
  logic          cond, step, reach;

  always_comb begin
    // Hot zones count toward release, cool zones toward tripping.
    cond    = hot_q ? (temp < hyst_lim) : (temp > set_lim);
    step    = hit & run;
    cnt_inc = {1'b0, cnt_q} + (CW+1)'(1);
    reach   = cnt_inc >= {1'b0, need};
    cnt_d     = cnt_q;
    hot_d     = hot_q;
    evt_over  = 1'b0;
    evt_under = 1'b0;
    if (step) begin
      if (cond) begin
        if (reach) begin
          hot_d     = ~hot_q;
          cnt_d     = '0;
          evt_over  = ~hot_q;
          evt_under = hot_q;
        end else begin
          cnt_d = cnt_inc[CW-1:0];
        end
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      hot_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      hot_q <= hot_d;
    end
  end

  // R3 / R9: state moves only on this zone's own conversion while running
  p_hold_without_conv_r3: assert property (@(posedge clk) disable iff (rst)
    !(hit && run) |=> $stable(hot_q) && $stable(cnt_q));

  // R2: a failing conversion empties the run
  p_miss_clears_r2: assert property (@(posedge clk) disable iff (rst)
    (hit && run && !cond) |=> (cnt_q == '0) && $stable(hot_q));
endmodule

// File: rtl/tz_irq_gen.sv
module tz_irq_gen #(
  parameter int NZ = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NZ-1:0] hot_d,
  input  logic [NZ-1:0] evt_over,
  input  logic [NZ-1:0] evt_under,
  input  logic          mode_intr,
  input  logic          irq_mask,
  input  logic          shutdown,
  input  logic          stat_rd,
  input  logic          any_rd,
  output logic          irq_n_q,
  output logic [NZ-1:0] stat_q
);
  logic [NZ-1:0] evt_rec, stat_d;
  logic          latch_q, latch_d, irq_n_d, rd_any;

  always_comb begin
    rd_any  = stat_rd | any_rd;
    // Comparator mode records only upward crossings; interrupt mode both.
    evt_rec = evt_over | (evt_under & {NZ{mode_intr}});

    if (shutdown) stat_d = '0;
    else          stat_d = (stat_q & ~{NZ{stat_rd}}) | evt_rec;

    if (shutdown || !mode_intr)        latch_d = 1'b0;
    else if ((|evt_rec) && !irq_mask)  latch_d = 1'b1;
    else if (rd_any)                   latch_d = 1'b0;
    else                               latch_d = latch_q;

    if (shutdown)       irq_n_d = 1'b1;
    else if (mode_intr) irq_n_d = ~(latch_d & ~irq_mask);
    else                irq_n_d = ~((|hot_d) & ~irq_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q  <= '0;
      latch_q <= 1'b0;
      irq_n_q <= 1'b1;
    end else begin
      stat_q  <= stat_d;
      latch_q <= latch_d;
      irq_n_q <= irq_n_d;
    end
  end

  // R9: shutdown quiets the line and empties status
  p_shutdown_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    shutdown |=> irq_n_q && (stat_q == '0));

  // R6 / R8: masked line never drives low
  p_mask_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    irq_mask |=> irq_n_q);

  // R6: a read with no new event releases an interrupt-mode line
  p_read_release_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_intr && rd_any && (evt_rec == '0)) |=> irq_n_q);

  // R5: status bits only go away through a status read or shutdown
  p_stat_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (!stat_rd && !shutdown) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

// File: rtl/tzone_irq_ctrl.sv
module tzone_irq_ctrl
  import tz_pkg::*;
#(
  parameter int TW    = 8,
  parameter int NZONE = 2,
  localparam int ZW   = (NZONE > 1) ? $clog2(NZONE) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                conv_done,
  input  logic [ZW-1:0]       conv_zone,
  input  logic [TW-1:0]       conv_temp,
  input  logic [NZONE*TW-1:0] set_lim,
  input  logic [NZONE*TW-1:0] hyst_lim,
  input  logic [1:0]          qdepth,
  input  logic                mode_intr,
  input  logic                irq_mask,
  input  logic                shutdown,
  input  logic                stat_rd,
  input  logic                any_rd,
  output logic                irq_n,
  output logic [NZONE-1:0]    zone_stat,
  output logic [NZONE-1:0]    zone_hot
);
  logic [QCNT_W-1:0]   need;
  logic [NZONE-1:0]    hot_d, evt_over, evt_under;
  logic signed [TW-1:0] temp_s;

  assign need   = run_len(qdepth);
  assign temp_s = conv_temp;

  for (genvar z = 0; z < NZONE; z++) begin : g_zone
    logic signed [TW-1:0] set_z, hyst_z;
    logic                 hit_z;
    assign set_z  = set_lim[z*TW +: TW];
    assign hyst_z = hyst_lim[z*TW +: TW];
    assign hit_z  = conv_done && (conv_zone == ZW'(z));

    tz_fault_queue #(.TW(TW), .CW(QCNT_W)) u_fq (
      .clk      (clk),
      .rst      (rst),
      .hit      (hit_z),
      .run      (~shutdown),
      .temp     (temp_s),
      .set_lim  (set_z),
      .hyst_lim (hyst_z),
      .need     (need),
      .hot_q    (zone_hot[z]),
      .hot_d    (hot_d[z]),
      .evt_over (evt_over[z]),
      .evt_under(evt_under[z])
    );
  end

  tz_irq_gen #(.NZ(NZONE)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .hot_d    (hot_d),
    .evt_over (evt_over),
    .evt_under(evt_under),
    .mode_intr(mode_intr),
    .irq_mask (irq_mask),
    .shutdown (shutdown),
    .stat_rd  (stat_rd),
    .any_rd   (any_rd),
    .irq_n_q  (irq_n),
    .stat_q   (zone_stat)
  );
endmodule

// File: tb/tzone_irq_ctrl_bench.sv
module tzone_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        conv_done = 1'b0;
  logic [0:0]  conv_zone = '0;
  logic [7:0]  conv_temp = '0;
  logic [15:0] set_lim, hyst_lim;
  logic [1:0]  qdepth = 2'd0;
  logic        mode_intr = 1'b0, irq_mask = 1'b0, shutdown = 1'b0;
  logic        stat_rd = 1'b0, any_rd = 1'b0;
  logic        irq_n;
  logic [1:0]  zone_stat, zone_hot;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // zone0: set 40, hyst 30; zone1: set -10, hyst -20
  localparam int SET0 = 40, HYS0 = 30, SET1 = -10, HYS1 = -20;
  assign set_lim  = {8'(SET1), 8'(SET0)};
  assign hyst_lim = {8'(HYS1), 8'(HYS0)};

  always #(CLK_PERIOD/2) clk = ~clk;

  tzone_irq_ctrl u_tzone_irq_ctrl (
    .clk(clk), .rst(rst), .conv_done(conv_done), .conv_zone(conv_zone),
    .conv_temp(conv_temp), .set_lim(set_lim), .hyst_lim(hyst_lim),
    .qdepth(qdepth), .mode_intr(mode_intr), .irq_mask(irq_mask),
    .shutdown(shutdown), .stat_rd(stat_rd), .any_rd(any_rd),
    .irq_n(irq_n), .zone_stat(zone_stat), .zone_hot(zone_hot));

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    conv_done = 1'b0; stat_rd = 1'b0; any_rd = 1'b0;
  endtask

  task automatic conv(input int z, input int t);
    conv_done = 1'b1; conv_zone = 1'(z); conv_temp = 8'(t);
    tick();
  endtask

  task automatic do_reset();
    rst = 1'b1; tick(); rst = 1'b0;
  endtask

  function automatic int run_of(input int code);
    return (code == 0) ? 1 : 2 * code;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int over_t, under_t, set_t, hys_t, d;
    tick(); tick(); rst = 1'b0; tick();
    // R11 reset state
    check("R11 irq_n", irq_n, 1);
    check("R11 stat", zone_stat, 0);
    check("R11 hot", zone_hot, 0);

    // R1/R2/R4/R8: every depth code, both zones, comparator mode
    for (int z = 0; z < 2; z++) begin
      set_t = (z == 0) ? SET0 : SET1;
      hys_t = (z == 0) ? HYS0 : HYS1;
      over_t = set_t + 1; under_t = hys_t - 1;
      for (int code = 0; code < 4; code++) begin
        qdepth = 2'(code); d = run_of(code);
        do_reset();
        for (int i = 0; i < d - 1; i++) begin
          conv(z, over_t); check("R1 short run", zone_hot[z], 0);
        end
        conv(z, set_t); check("R2 equal breaks run", zone_hot[z], 0);
        for (int i = 0; i < d - 1; i++) begin
          conv(z, over_t); check("R2 rerun short", zone_hot[z], 0);
        end
        conv(z, over_t);
        check("R1 full run trips", zone_hot[z], 1);
        check("R8 cmp line low", irq_n, 0);
        for (int i = 0; i < d - 1; i++) begin
          conv(z, under_t); check("R4 short release", zone_hot[z], 1);
        end
        conv(z, hys_t); check("R4 equal hyst no count", zone_hot[z], 1);
        for (int i = 0; i < d - 1; i++) begin
          conv(z, under_t); check("R4 release rerun", zone_hot[z], 1);
        end
        conv(z, under_t);
        check("R4 full release", zone_hot[z], 0);
        check("R8 cmp line high", irq_n, 1);
      end
    end

    // R3: zones count independently (depth 2)
    qdepth = 2'd1; do_reset();
    conv(0, SET0 + 1);
    conv(1, -100);
    conv(0, SET0 + 1);
    check("R3 zone0 unaffected", zone_hot[0], 1);
    check("R3 zone1 cool", zone_hot[1], 0);

    // R10: exhaustive signed sweep against set and hysteresis limits
    qdepth = 2'd0;
    for (int t = -128; t < 128; t++) begin
      do_reset();
      conv(0, t); check("R10 set z0", zone_hot[0], (t > SET0) ? 1 : 0);
      conv(1, t); check("R10 set z1", zone_hot[1], (t > SET1) ? 1 : 0);
      do_reset();
      conv(1, 127); conv(1, t);
      check("R10 hyst z1", zone_hot[1], (t < HYS1) ? 0 : 1);
    end

    // R6/R7/R5: interrupt mode sequence
    mode_intr = 1'b1; irq_mask = 1'b0; do_reset();
    conv(0, SET0 + 1);
    check("R6 event fires", irq_n, 0);
    check("R5 stat set", zone_stat, 1);
    any_rd = 1'b1; tick();
    check("R6 read releases", irq_n, 1);
    check("R5 other read keeps stat", zone_stat, 1);
    conv(0, SET0 + 5);
    check("R7 no refire while hot", irq_n, 1);
    conv(0, HYS0 - 1);
    check("R7 downward event fires", irq_n, 0);
    stat_rd = 1'b1; tick();
    check("R5 stat read clears", zone_stat, 0);
    check("R6 stat read releases", irq_n, 1);
    stat_rd = 1'b1; conv(0, SET0 + 1);
    check("R5 event beats read", zone_stat, 1);
    check("R7 upward rearmed", irq_n, 0);
    tick();
    check("R6 line holds without read", irq_n, 0);

    // R6/R5: masked events set status but never the line
    irq_mask = 1'b1; do_reset();
    conv(0, SET0 + 1);
    check("R5 masked stat set", zone_stat, 1);
    check("R6 masked line high", irq_n, 1);
    conv(0, HYS0 - 1); conv(0, SET0 + 1);
    check("R5 sticky multi event", zone_stat, 1);
    irq_mask = 1'b0; tick();
    check("R6 unmask no stale", irq_n, 1);
    stat_rd = 1'b1; tick();
    check("R5 cleared after read", zone_stat, 0);

    // R9: shutdown in interrupt mode
    do_reset();
    conv(0, SET0 + 1);
    check("R9 pre irq", irq_n, 0);
    shutdown = 1'b1; tick();
    check("R9 sd line high", irq_n, 1);
    check("R9 sd stat clear", zone_stat, 0);
    conv(0, HYS0 - 1);
    check("R9 sd conv ignored", zone_hot[0], 1);
    check("R9 sd no event", zone_stat, 0);
    shutdown = 1'b0; tick();
    check("R9 no stale latch", irq_n, 1);
    conv(0, HYS0 - 1);
    check("R9 resumes events", irq_n, 0);

    // R8/R9: comparator mode reads and shutdown
    mode_intr = 1'b0; do_reset();
    conv(1, SET1 + 1);
    check("R8 cmp hot low", irq_n, 0);
    any_rd = 1'b1; stat_rd = 1'b1; tick();
    check("R8 reads no release", irq_n, 0);
    shutdown = 1'b1; tick();
    check("R9 cmp sd high", irq_n, 1);
    shutdown = 1'b0; tick();
    check("R8 cmp follows hot again", irq_n, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule